// File: doc/BRIEF.md
# Six-Source Vectored Interrupt Controller

This block collects six interrupt requests into a pending register, chooses one winner under a programmable priority scheme, and offers it to the processor core as a vector address through a request/acknowledge handshake. Three requests come from falling edges on three asynchronous input pins. A fourth comes from a rising edge on the middle pin. The last two are single-cycle pulses from two timer channels.

Software sees three 8-bit registers through a simple write strobe and a combinational read port. The pending register shows latched requests and clears bits when 1s are written to them. The enable register holds the per-source enables and a global enable. The priority register orders three source pairs and picks the preferred member of each pair. When software leaves the enables off, the pending register still records every event, so the controller also serves a polled design.

When the core acknowledges a grant, the controller clears the granted pending bit and drops the global enable. No further grant is offered until software sets the global enable again.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the pending register, the enable register (including global enable) and the priority register all read 0, and `grant_req_o` is low.
- R2: Source 0, 1 and 2 pending bits are set by a falling edge on `pin_i[0]`, `pin_i[1]` and `pin_i[2]`. Source 3 is set by a rising edge on `pin_i[1]`. Each pin passes through a two-flop synchronizer and an edge register, so the bit reads set after the third rising clock edge that follows the pin change. The bit is set exactly once per transition. The synchronizers reset to high.
- R3: A high cycle on `tmr_pulse_i[0]` sets pending bit 4, and a high cycle on `tmr_pulse_i[1]` sets bit 5. The bit reads set right after that clock edge.
- R4: Pending bits latch whatever the per-source enables and the global enable are. Select 0 reads the pending bits on data bits [5:0], with bits [7:6] reading 0.
- R5: Writing select 0 clears each pending bit whose data bit is 1. A clear from software or from an acknowledge loses to a set that happens in the same cycle.
- R6: Select 1 holds the per-source enables in bits [5:0] and the global enable in bit 7. A grant is raised one cycle after global enable is 1 and at least one enabled source is pending. Pending sources that are not enabled never win.
- R7: Select 2 holds a group order code in bits [2:0] and one swap bit per group in bits [5:3]. Group g covers sources 2g and 2g+1. The order codes, highest priority group first, are: 0 = 0,1,2; 1 = 0,2,1; 2 = 1,0,2; 3 = 1,2,0; 4 = 2,0,1; 5 = 2,1,0; 6 and 7 behave as 0. Within a group the even source wins, unless the group's swap bit is set.
- R8: While `grant_req_o` is high, `grant_src_o` gives the winning source and `grant_vec_o` = VEC_BASE + 2 × source. That is the first byte of the two-byte handler address.
- R9: `grant_req_o`, `grant_src_o` and `grant_vec_o` stay unchanged until a cycle with `grant_ack_i` high. At that edge, the granted pending bit and the global enable clear, and `grant_req_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 3 | Asynchronous external request pins |
| tmr_pulse_i | input | 2 | Timer channel request pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 pending, 1 enable, 2 priority) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| grant_req_o | output | 1 | Interrupt grant request to the core |
| grant_src_o | output | 3 | Winning source index |
| grant_vec_o | output | 16 | Program-memory address of the winner's vector |
| grant_ack_i | input | 1 | Core acknowledge of the grant |

## Verification
Every register in this block shows up at the ports within a few cycles. A bad synchronizer or edge register either misses a pending bit or sets it one cycle off, and the pending read shows this three edges after a pin change. A wrong priority decode shows up in `grant_src_o` and `grant_vec_o` on the very cycle the grant rises. A lost or stuck global enable shows up either as a grant that never comes or as a second grant on the cycle after an acknowledge. Because the bench compares against a reference model on every clock, any of these faults is caught on the first cycle where it differs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 6;
  localparam int NPIN   = 3;
  localparam int NTMR   = 2;
  localparam int NGRP   = NSRC / 2;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int DW     = 8;
  localparam int GE_BIT = 7;

  typedef logic [SRC_W-1:0] src_idx_t;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int SRC_TMR0 = 4;
  localparam int SRC_RISE = 3;
  localparam int RISE_PIN = 1;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i]   <= 1'b1;
        s2_q[i]   <= 1'b1;
        prev_q[i] <= 1'b1;
      end else begin
        s1_q[i]   <= pin_i[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
      end
    end
    assign fall_o[i] = prev_q[i] & ~s2_q[i];
    assign rise_o[i] = ~prev_q[i] & s2_q[i];
  end

  // one pulse per transition
  p_edge_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_o) |=> ((fall_o & $past(fall_o)) == '0));
  p_rise_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [2:0]      order_i,
  input  logic [NGRP-1:0] swap_i,
  output logic            valid_o,
  output src_idx_t        idx_o
);
  logic [NGRP-1:0] grp_any;
  src_idx_t        grp_pick [NGRP];
  logic [1:0]      rank [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam src_idx_t LO = src_idx_t'(2 * g);
    localparam src_idx_t HI = src_idx_t'(2 * g + 1);
    assign grp_any[g] = req_i[2*g] | req_i[2*g+1];
    always_comb begin
      if (swap_i[g]) grp_pick[g] = req_i[2*g+1] ? HI : LO;
      else           grp_pick[g] = req_i[2*g]   ? LO : HI;
    end
  end

  always_comb begin
    case (order_i)
      3'd1:    begin rank[0] = 2'd0; rank[1] = 2'd2; rank[2] = 2'd1; end
      3'd2:    begin rank[0] = 2'd1; rank[1] = 2'd0; rank[2] = 2'd2; end
      3'd3:    begin rank[0] = 2'd1; rank[1] = 2'd2; rank[2] = 2'd0; end
      3'd4:    begin rank[0] = 2'd2; rank[1] = 2'd0; rank[2] = 2'd1; end
      3'd5:    begin rank[0] = 2'd2; rank[1] = 2'd1; rank[2] = 2'd0; end
      default: begin rank[0] = 2'd0; rank[1] = 2'd1; rank[2] = 2'd2; end
    endcase
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = NGRP - 1; k >= 0; k--) begin
      if (grp_any[rank[k]]) begin
        valid_o = 1'b1;
        idx_o   = grp_pick[rank[k]];
      end
    end
  end

  p_win_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[idx_o]);
  p_any_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> valid_o);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_AW   = 16,
  parameter int VEC_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NTMR-1:0]   tmr_pulse_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              grant_req_o,
  output logic [SRC_W-1:0]  grant_src_o,
  output logic [VEC_AW-1:0] grant_vec_o,
  input  logic              grant_ack_i
);
  logic [NPIN-1:0] pin_fall, pin_rise;
  logic [NSRC-1:0] pend_q, pend_set, pend_clr, en_q, eligible;
  logic            ge_q;
  logic [2:0]      order_q;
  logic [NGRP-1:0] swap_q;
  logic            win_valid, ack_hit;
  src_idx_t        win_idx, src_q;
  logic [VEC_AW-1:0] vec_q;
  logic            req_q;

  irq_edge_det #(.N(NPIN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .fall_o (pin_fall),
    .rise_o (pin_rise)
  );

  always_comb begin
    pend_set = '0;
    pend_set[NPIN-1:0] = pin_fall;
    pend_set[SRC_RISE] = pin_rise[RISE_PIN];
    pend_set[SRC_TMR0 +: NTMR] = tmr_pulse_i;
  end

  assign ack_hit = req_q & grant_ack_i;

  always_comb begin
    pend_clr = '0;
    if (reg_we_i && reg_sel_e'(reg_sel_i) == SEL_PEND) pend_clr = reg_wdata_i[NSRC-1:0];
    if (ack_hit) pend_clr[src_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | pend_set;  // set wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      ge_q    <= 1'b0;
      order_q <= '0;
      swap_q  <= '0;
    end else begin
      if (reg_we_i && reg_sel_e'(reg_sel_i) == SEL_EN) begin
        en_q <= reg_wdata_i[NSRC-1:0];
        ge_q <= reg_wdata_i[GE_BIT];
      end
      if (reg_we_i && reg_sel_e'(reg_sel_i) == SEL_PRIO) begin
        order_q <= reg_wdata_i[2:0];
        swap_q  <= reg_wdata_i[3 +: NGRP];
      end
      if (ack_hit) ge_q <= 1'b0;  // acknowledge overrides software
    end
  end

  assign eligible = ge_q ? (pend_q & en_q) : '0;

  irq_prio_enc u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (eligible),
    .order_i (order_q),
    .swap_i  (swap_q),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
    end else if (ack_hit) begin
      req_q <= 1'b0;
    end else if (!req_q && win_valid) begin
      req_q <= 1'b1;
      src_q <= win_idx;
      vec_q <= VEC_AW'(VEC_BASE) + VEC_AW'({win_idx, 1'b0});
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_e'(reg_sel_i))
      SEL_PEND: reg_rdata_o[NSRC-1:0] = pend_q;
      SEL_EN: begin
        reg_rdata_o[NSRC-1:0] = en_q;
        reg_rdata_o[GE_BIT]   = ge_q;
      end
      SEL_PRIO: begin
        reg_rdata_o[2:0]      = order_q;
        reg_rdata_o[3 +: NGRP] = swap_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign grant_req_o = req_q;
  assign grant_src_o = src_q;
  assign grant_vec_o = vec_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_req_o && !grant_ack_i) |=> (grant_req_o && $stable(grant_vec_o) && $stable(grant_src_o)));
  p_ack_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_req_o && grant_ack_i) |=> (!grant_req_o && !ge_q));
  p_needs_ge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_req_o) |-> $past(ge_q));
  p_src_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_req_o |-> (grant_src_o < SRC_W'(NSRC)));
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_set) |=> ((pend_q & $past(pend_set)) == $past(pend_set)));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin = 3'b111;
  logic [1:0] tmr = 2'b00;
  logic       we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       greq;
  logic [2:0] gsrc;
  logic [15:0] gvec;
  logic       ack = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tmr_pulse_i(tmr),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .grant_req_o(greq), .grant_src_o(gsrc), .grant_vec_o(gvec), .grant_ack_i(ack)
  );

  // reference model
  logic [2:0] m_s1, m_s2, m_pv;
  logic [5:0] m_pend, m_en;
  logic       m_ge, m_req;
  logic [7:0] m_prio;
  int         m_src;

  function automatic int pick(logic [5:0] e, logic [2:0] code, logic [2:0] sw);
    int ord[3];
    case (code)
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      3'd5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    for (int k = 0; k < 3; k++) begin
      int a = 2 * ord[k];
      int b = a + 1;
      if (sw[ord[k]]) begin int t = a; a = b; b = t; end
      if (e[a]) return a;
      if (e[b]) return b;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 3'b111; m_s2 = 3'b111; m_pv = 3'b111;
      m_pend = 0; m_en = 0; m_ge = 0; m_req = 0; m_prio = 0; m_src = 0;
    end else begin
      logic [5:0] set, np;
      logic ge_old;
      int w;
      set = 0;
      for (int i = 0; i < 3; i++) set[i] = m_pv[i] && !m_s2[i];
      set[3] = !m_pv[1] && m_s2[1];
      set[4] = tmr[0];
      set[5] = tmr[1];
      ge_old = m_ge;
      w = ge_old ? pick(m_pend & m_en, m_prio[2:0], m_prio[5:3]) : -1;
      np = m_pend;
      if (we && sel == 2'd0) np = np & ~wdata[5:0];
      if (we && sel == 2'd1) begin m_en = wdata[5:0]; m_ge = wdata[7]; end
      if (we && sel == 2'd2) m_prio = {2'b00, wdata[5:0]};
      if (m_req && ack) begin
        np[m_src] = 1'b0;
        m_ge = 0;
        m_req = 0;
      end else if (!m_req && w >= 0) begin
        m_req = 1;
        m_src = w;
      end
      m_pend = np | set;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  function automatic logic [7:0] m_rd(logic [1:0] s);
    case (s)
      2'd0: return {2'b00, m_pend};
      2'd1: return {m_ge, 1'b0, m_en};
      2'd2: return m_prio;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare against model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 grant_req", greq, m_req);
      check("R4 read data", rdata, m_rd(sel));
      if (m_req) begin
        check("R7 grant_src", gsrc, m_src);
        check("R8 grant_vec", gvec, 2 * m_src);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    we = 1; sel = s; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic rd(logic [1:0] s, logic [7:0] exp, string tag);
    sel = s;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic wait_grant(int exp_src, string tag);
    for (int i = 0; i < 5 && !greq; i++) tick();
    @(negedge clk);
    check({tag, " req"}, greq, 1);
    check({tag, " src"}, gsrc, exp_src);
    check({tag, " vec R8"}, gvec, 2 * exp_src);
  endtask

  task automatic do_ack();
    @(posedge clk); #1;
    ack = 1;
    tick();
    ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    rd(2'd0, 8'h00, "R1 pend");
    rd(2'd1, 8'h00, "R1 enable");
    rd(2'd2, 8'h00, "R1 prio");
    check("R1 grant_req", greq, 0);

    // R2 falling edge on pin0, latency of three edges
    tick();
    pin[0] = 0;
    tick(2);
    rd(2'd0, 8'h00, "R2 not yet");
    tick();
    rd(2'd0, 8'h01, "R2 pin0 fall");
    // once per transition
    wr(2'd0, 8'h01);
    tick(6);
    rd(2'd0, 8'h00, "R2 held low no retrigger");
    pin[1] = 0; tick(4);
    rd(2'd0, 8'h02, "R2 pin1 fall");
    pin[1] = 1; tick(4);
    rd(2'd0, 8'h0A, "R2 pin1 rise");
    pin[2] = 0; tick(4);
    rd(2'd0, 8'h0E, "R2 pin2 fall");
    pin[0] = 1; tick(4);
    rd(2'd0, 8'h0E, "R2 pin0 rise ignored");

    // R3 timers, R4 latch while masked
    tmr = 2'b01; tick(); tmr = 2'b00;
    rd(2'd0, 8'h1E, "R3 tmr0");
    tmr = 2'b10; tick(); tmr = 2'b00;
    rd(2'd0, 8'h3E, "R3 tmr1 R4 latched while masked");
    check("R6 no grant when disabled", greq, 0);

    // R5 set wins over W1C
    we = 1; sel = 2'd0; wdata = 8'h10; tmr = 2'b01;
    tick();
    we = 0; tmr = 2'b00;
    rd(2'd0, 8'h3E, "R5 set wins over clear");
    wr(2'd0, 8'h3F);
    rd(2'd0, 8'h00, "R5 w1c all");
    pin[0] = 0; tick(4);
    tmr = 2'b11; tick(); tmr = 2'b00;
    pin[2] = 1; tick(4);
    pin[1] = 0; tick(4);
    pin[1] = 1; tick(4);
    pin[2] = 0; tick(4);
    rd(2'd0, 8'h3F, "R2 all pending");

    // R6 global enable with nothing enabled
    wr(2'd1, 8'h80);
    tick(4);
    check("R6 no enabled source", greq, 0);
    wr(2'd1, 8'h00);

    // R7 default order, R8 vector
    wr(2'd1, 8'hBF);
    wait_grant(0, "R7 default order");
    do_ack();
    rd(2'd1, 8'h3F, "R9 ge cleared by ack");
    rd(2'd0, 8'h3E, "R9 bit cleared by ack");
    tick(3);
    check("R9 no regrant", greq, 0);

    // R7 order 5, group2 swap
    wr(2'd2, 8'h25);
    wr(2'd1, 8'hBF);
    wait_grant(5, "R7 order5 swap");
    wr(2'd2, 8'h00);
    tick(8);
    @(negedge clk);
    check("R9 held src", gsrc, 5);
    check("R9 held vec", gvec, 10);
    do_ack();

    // R7 order 3, group1 swap
    wr(2'd2, 8'h13);
    wr(2'd1, 8'hBF);
    wait_grant(3, "R7 order3 swap");
    do_ack();
    rd(2'd0, 8'h16, "R9 pend after ack3");

    // R6 enable subset
    wr(2'd1, 8'h84);
    wait_grant(2, "R6 only bit2 enabled");
    do_ack();

    // R5 ack clear loses to timer set
    wr(2'd1, 8'h90);
    wait_grant(4, "R6 only bit4");
    @(posedge clk); #1;
    ack = 1; tmr = 2'b01;
    tick();
    ack = 0; tmr = 2'b00;
    rd(2'd0, 8'h12, "R5 set wins over ack");
    tick(3);
    check("R9 ge off after ack", greq, 0);

    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule